// File: doc/BRIEF.md
# Adaptive Insertion Replacement Controller

This block holds the replacement state of one set-associative cache and decides, for every lookup result, which way is touched and where that way lands in the set's recency order. Each set keeps a recency rank for every way together with a valid bit per way. A hit always promotes the touched way to the most-recent rank. A miss fills a way, either the lowest-numbered invalid way or the way holding the least-recent rank, and the controller chooses whether the new line enters at the most-recent rank or at the least-recent rank.

The insertion choice adapts at run time. A small group of sampled sets always inserts at the most-recent rank; a second group always uses a bimodal rule, which inserts at the most-recent rank only when the low bits of a free-running pseudo-random register are all zero and otherwise inserts at the least-recent rank. Misses in the two sampled groups push a saturating selector counter in opposite directions. All other sets, the followers, copy whichever rule the top bit of the selector currently favours. Tag and data arrays sit outside; the surrounding cache presents one access per cycle with its hit flag, hit way and set index, and receives the chosen way and the set's new rank vector one cycle later.

The controller has two states. In SWEEP, entered on reset, it walks one set per cycle, clearing the valid bits and loading the identity ranking (way i at rank i); accesses are not accepted. The transition SWEEP_DONE, taken when the last set has been written, moves it to READY, where it serves one access per cycle and stays until the next reset.

Top module: `rdp_ctrl`

## Requirements
- R1: After reset the controller spends exactly SETS cycles in SWEEP with `ready` low, ignoring any access (`rsp_valid` stays 0); it then raises `ready` and never lowers it until reset.
- R2: An accepted hit on way w returns, one cycle later, `rsp_valid`=1, `rsp_way`=w, `rsp_mru`=1, with way w at rank 0; every way whose old rank lay below w's old rank moves down by exactly one, the rest keep their rank.
- R3: An accepted miss fills the lowest-numbered invalid way of the set if any, otherwise the way holding rank WAYS-1; the filled way becomes valid.
- R4: A set whose index modulo STRIDE (SETS/LEADERS) is 0 is a recency leader: every miss there inserts at rank 0.
- R5: A set whose index modulo STRIDE is STRIDE-1 is a bimodal leader: a miss there inserts at rank 0 only when the low BIM_BITS bits of the random register are all zero at the access edge, and otherwise at rank WAYS-1 (reported as `rsp_mru`=0); ways between the old and new rank move up by one.
- R6: The random register is 16 bits wide, is loaded with 16'hACE1 in reset, and advances on every clock edge out of reset as x <= {x[14:0], x[15]^x[13]^x[12]^x[10]}.
- R7: The selector (PSEL_W bits) resets to 2^(PSEL_W-1)-1, increments on a miss in a recency leader, decrements on a miss in a bimodal leader, saturates at 0 and 2^PSEL_W-1, and is unchanged by hits.
- R8: A follower set uses the bimodal rule of R5 when the selector's top bit is 1 and always inserts at rank 0 when it is 0.
- R9: `rsp_stack` holds the new rank of way i in bits [i*WAY_W +: WAY_W]; the ranks of a set always form a permutation of 0..WAYS-1.
- R10: A cycle without an accepted access gives `rsp_valid`=0 in the next cycle and changes no set's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_hit | input | 1 | The access hit in the tag array |
| acc_way | input | WAY_W | Way that hit (ignored on a miss) |
| acc_set | input | SET_W | Set index of the access |
| ready | output | 1 | Sweep complete, accesses accepted |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_way | output | WAY_W | Way hit or filled |
| rsp_mru | output | 1 | The way was placed at rank 0 |
| rsp_stack | output | WAYS*WAY_W | New rank of every way of the accessed set |

## Verification
A corrupted rank vector shows up in `rsp_stack` on the very next access to the same set, either as a repeated rank or as a way that moved by the wrong amount, so the bench compares every rank of every response against its own model. A wrong selector value stays hidden until a follower set misses, and then appears as a wrong `rsp_mru` and rank for the filled way; the bench drives the selector into both saturation limits and then probes followers so that such drift surfaces within a few hundred accesses. A slip of the random register by even one step changes which bimodal fills land at rank 0, visible on the first such fill.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_READY = 1'b1
    } rdp_state_e;

    typedef enum logic [1:0] {
        KIND_FOLLOW   = 2'd0,
        KIND_LEAD_REC = 2'd1,
        KIND_LEAD_BIM = 2'd2
    } set_kind_e;

    localparam logic [15:0] RAND_SEED = 16'hACE1;

    function automatic logic [15:0] rand_next(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

endpackage

// File: rtl/rdp_victim_pick.sv
module rdp_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       vld,
    input  logic [WAYS*WAY_W-1:0] pos,
    output logic [WAY_W-1:0]      victim
);
    localparam logic [WAY_W-1:0] LAST_RANK = WAY_W'(WAYS - 1);

    logic             free_found;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] tail_way;

    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(i);
            end
        end
    end

    always_comb begin
        tail_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (pos[i*WAY_W +: WAY_W] == LAST_RANK) begin
                tail_way = WAY_W'(i);
            end
        end
    end

    assign victim = free_found ? free_way : tail_way;

endmodule

// File: rtl/rdp_stack_update.sv
module rdp_stack_update #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS*WAY_W-1:0] pos_in,
    input  logic [WAY_W-1:0]      tgt_way,
    input  logic [WAY_W-1:0]      tgt_rank,
    output logic [WAYS*WAY_W-1:0] pos_out
);
    logic [WAY_W-1:0] old_rank;

    assign old_rank = pos_in[tgt_way*WAY_W +: WAY_W];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [WAY_W-1:0] cur;
        logic             move_down;
        logic             move_up;

        assign cur       = pos_in[g*WAY_W +: WAY_W];
        assign move_down = (tgt_rank < old_rank) && (cur >= tgt_rank) && (cur < old_rank);
        assign move_up   = (tgt_rank > old_rank) && (cur > old_rank) && (cur <= tgt_rank);

        always_comb begin
            if (tgt_way == WAY_W'(g)) begin
                pos_out[g*WAY_W +: WAY_W] = tgt_rank;
            end else if (move_down) begin
                pos_out[g*WAY_W +: WAY_W] = cur + 1'b1;
            end else if (move_up) begin
                pos_out[g*WAY_W +: WAY_W] = cur - 1'b1;
            end else begin
                pos_out[g*WAY_W +: WAY_W] = cur;
            end
        end
    end

endmodule

// File: rtl/rdp_policy_sel.sv
module rdp_policy_sel
    import rdp_pkg::*;
#(
    parameter int SETS     = 64,
    parameter int LEADERS  = 8,
    parameter int PSEL_W   = 10,
    parameter int BIM_BITS = 5,
    parameter int SET_W    = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             miss_evt,
    output logic             mru_ins
);
    localparam int STRIDE = SETS / LEADERS;
    localparam int OFF_W  = $clog2(STRIDE);
    localparam logic [PSEL_W-1:0] PSEL_INIT = PSEL_W'((1 << (PSEL_W - 1)) - 1);
    localparam logic [PSEL_W-1:0] PSEL_MAX  = '1;

    logic [15:0]       rnd_q;
    logic [PSEL_W-1:0] psel_q;
    logic [OFF_W-1:0]  off;
    set_kind_e         kind;
    logic              bim_mru;

    assign off     = set_idx[OFF_W-1:0];
    assign bim_mru = (rnd_q[BIM_BITS-1:0] == '0);

    always_comb begin
        if (off == '0) begin
            kind = KIND_LEAD_REC;
        end else if (off == OFF_W'(STRIDE - 1)) begin
            kind = KIND_LEAD_BIM;
        end else begin
            kind = KIND_FOLLOW;
        end
    end

    always_comb begin
        unique case (kind)
            KIND_LEAD_REC: mru_ins = 1'b1;
            KIND_LEAD_BIM: mru_ins = bim_mru;
            KIND_FOLLOW:   mru_ins = psel_q[PSEL_W-1] ? bim_mru : 1'b1;
            default:       mru_ins = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q <= RAND_SEED;
        end else begin
            rnd_q <= rand_next(rnd_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psel_q <= PSEL_INIT;
        end else if (miss_evt) begin
            if (kind == KIND_LEAD_REC && psel_q != PSEL_MAX) begin
                psel_q <= psel_q + 1'b1;
            end else if (kind == KIND_LEAD_BIM && psel_q != '0) begin
                psel_q <= psel_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
    import rdp_pkg::*;
#(
    parameter int WAYS     = 4,
    parameter int SETS     = 64,
    parameter int LEADERS  = 8,
    parameter int PSEL_W   = 10,
    parameter int BIM_BITS = 5,
    parameter int WAY_W    = $clog2(WAYS),
    parameter int SET_W    = $clog2(SETS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic                   acc_hit,
    input  logic [WAY_W-1:0]       acc_way,
    input  logic [SET_W-1:0]       acc_set,
    output logic                   ready,
    output logic                   rsp_valid,
    output logic [WAY_W-1:0]       rsp_way,
    output logic                   rsp_mru,
    output logic [WAYS*WAY_W-1:0]  rsp_stack
);
    localparam int STACK_W = WAYS * WAY_W;
    localparam logic [SET_W-1:0] LAST_SET  = SET_W'(SETS - 1);
    localparam logic [WAY_W-1:0] LAST_RANK = WAY_W'(WAYS - 1);

    rdp_state_e       state_q;
    rdp_state_e       state_d;
    logic [SET_W-1:0] sweep_q;

    logic [STACK_W-1:0] pos_mem [SETS];
    logic [WAYS-1:0]    vld_mem [SETS];

    logic [STACK_W-1:0] ident;
    logic [STACK_W-1:0] cur_pos;
    logic [WAYS-1:0]    cur_vld;
    logic [WAY_W-1:0]   victim;
    logic               mru_ins;
    logic               take;
    logic               miss_evt;
    logic               sweep_wr;
    logic [WAY_W-1:0]   tgt_way;
    logic [WAY_W-1:0]   tgt_rank;
    logic               tgt_mru;
    logic [STACK_W-1:0] new_pos;
    logic [WAYS-1:0]    new_vld;

    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            ident[i*WAY_W +: WAY_W] = WAY_W'(i);
        end
    end

    assign cur_pos = pos_mem[acc_set];
    assign cur_vld = vld_mem[acc_set];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            sweep_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SWEEP) begin
                sweep_q <= sweep_q + 1'b1;
            end
        end
    end

    // next state and per-state outputs
    always_comb begin
        state_d  = state_q;
        ready    = 1'b0;
        sweep_wr = 1'b0;
        unique case (state_q)
            ST_SWEEP: begin
                sweep_wr = 1'b1;
                if (sweep_q == LAST_SET) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                ready = 1'b1;
            end
            default: begin
                state_d = ST_SWEEP;
            end
        endcase
    end

    assign take     = ready && acc_valid;
    assign miss_evt = take && !acc_hit;

    rdp_victim_pick #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_pick (
        .vld    (cur_vld),
        .pos    (cur_pos),
        .victim (victim)
    );

    rdp_policy_sel #(
        .SETS     (SETS),
        .LEADERS  (LEADERS),
        .PSEL_W   (PSEL_W),
        .BIM_BITS (BIM_BITS),
        .SET_W    (SET_W)
    ) u_policy (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_idx  (acc_set),
        .miss_evt (miss_evt),
        .mru_ins  (mru_ins)
    );

    assign tgt_way  = acc_hit ? acc_way : victim;
    assign tgt_mru  = acc_hit || mru_ins;
    assign tgt_rank = tgt_mru ? '0 : LAST_RANK;

    rdp_stack_update #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_upd (
        .pos_in   (cur_pos),
        .tgt_way  (tgt_way),
        .tgt_rank (tgt_rank),
        .pos_out  (new_pos)
    );

    always_comb begin
        new_vld = cur_vld;
        new_vld[tgt_way] = 1'b1;
    end

    // replacement state storage
    always_ff @(posedge clk) begin
        if (sweep_wr) begin
            pos_mem[sweep_q] <= ident;
            vld_mem[sweep_q] <= '0;
        end else if (take) begin
            pos_mem[acc_set] <= new_pos;
            vld_mem[acc_set] <= new_vld;
        end
    end

    // response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_way   <= '0;
            rsp_mru   <= 1'b0;
            rsp_stack <= '0;
        end else begin
            rsp_valid <= take;
            if (take) begin
                rsp_way   <= tgt_way;
                rsp_mru   <= tgt_mru;
                rsp_stack <= new_pos;
            end
        end
    end

endmodule

// File: rtl/rdp_ctrl_chk.sv
module rdp_ctrl_chk #(
    parameter int WAYS    = 4,
    parameter int SETS    = 64,
    parameter int LEADERS = 8,
    parameter int WAY_W   = $clog2(WAYS),
    parameter int SET_W   = $clog2(SETS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  acc_valid,
    input logic                  acc_hit,
    input logic [WAY_W-1:0]      acc_way,
    input logic [SET_W-1:0]      acc_set,
    input logic                  ready,
    input logic                  rsp_valid,
    input logic [WAY_W-1:0]      rsp_way,
    input logic                  rsp_mru,
    input logic [WAYS*WAY_W-1:0] rsp_stack
);
    localparam int STRIDE = SETS / LEADERS;
    localparam int OFF_W  = $clog2(STRIDE);

    logic [WAYS-1:0]  seen;
    logic [WAY_W-1:0] way_rank;
    logic             rec_leader;

    always_comb begin
        seen = '0;
        for (int i = 0; i < WAYS; i++) begin
            seen[rsp_stack[i*WAY_W +: WAY_W]] = 1'b1;
        end
    end

    assign way_rank   = rsp_stack[rsp_way*WAY_W +: WAY_W];
    assign rec_leader = (acc_set[OFF_W-1:0] == '0);

    assert_ready_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && acc_valid) |=> !rsp_valid);

    assert_rsp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && acc_valid) |=> rsp_valid);

    assert_hit_promote_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && acc_valid && acc_hit) |=>
            (rsp_mru && rsp_way == $past(acc_way) && way_rank == '0));

    assert_rec_leader_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && acc_valid && !acc_hit && rec_leader) |=> rsp_mru);

    assert_rank_consistent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_mru ? (way_rank == '0) : (way_rank == WAY_W'(WAYS - 1))));

    assert_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(seen) == WAYS));

endmodule

bind rdp_ctrl rdp_ctrl_chk #(
    .WAYS    (WAYS),
    .SETS    (SETS),
    .LEADERS (LEADERS),
    .WAY_W   (WAY_W),
    .SET_W   (SET_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_hit   (acc_hit),
    .acc_way   (acc_way),
    .acc_set   (acc_set),
    .ready     (ready),
    .rsp_valid (rsp_valid),
    .rsp_way   (rsp_way),
    .rsp_mru   (rsp_mru),
    .rsp_stack (rsp_stack)
);

// File: tb/rdp_ctrl_bench.sv
module rdp_ctrl_bench;
    localparam int WAYS     = 4;
    localparam int SETS     = 64;
    localparam int LEADERS  = 8;
    localparam int PSEL_W   = 10;
    localparam int BIM_BITS = 5;
    localparam int WAY_W    = 2;
    localparam int SET_W    = 6;
    localparam int STRIDE   = SETS / LEADERS;
    localparam int PSEL_MAXV = (1 << PSEL_W) - 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  acc_valid = 1'b0;
    logic                  acc_hit = 1'b0;
    logic [WAY_W-1:0]      acc_way = '0;
    logic [SET_W-1:0]      acc_set = '0;
    logic                  ready;
    logic                  rsp_valid;
    logic [WAY_W-1:0]      rsp_way;
    logic                  rsp_mru;
    logic [WAYS*WAY_W-1:0] rsp_stack;

    always #5 clk = ~clk;

    rdp_ctrl #(
        .WAYS (WAYS), .SETS (SETS), .LEADERS (LEADERS),
        .PSEL_W (PSEL_W), .BIM_BITS (BIM_BITS)
    ) u_rdp_ctrl (
        .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_hit (acc_hit),
        .acc_way (acc_way), .acc_set (acc_set), .ready (ready),
        .rsp_valid (rsp_valid), .rsp_way (rsp_way), .rsp_mru (rsp_mru),
        .rsp_stack (rsp_stack)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int m_rank [SETS][WAYS];
    bit m_vld  [SETS][WAYS];
    int m_psel;
    logic [15:0] m_rnd;
    bit m_ready;
    int m_sweep;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_next(input logic [15:0] x);
        // R6 feedback taps
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                m_rank[s][w] = w;
                m_vld[s][w]  = 1'b0;
            end
        end
        m_psel  = (1 << (PSEL_W - 1)) - 1;
        m_rnd   = 16'hACE1;
        m_ready = 1'b0;
        m_sweep = 0;
    endtask

    task automatic move_to(input int s, input int w, input int r);
        int order[$];
        for (int p = 0; p < WAYS; p++) begin
            for (int k = 0; k < WAYS; k++) begin
                if (m_rank[s][k] == p && k != w) order.push_back(k);
            end
        end
        order.insert(r, w);
        for (int p = 0; p < WAYS; p++) m_rank[s][order[p]] = p;
    endtask

    task automatic tick(input bit a, input bit h, input int w, input int s, input string tag);
        bit exp_valid;
        int exp_way;
        bit exp_mru;
        bit bim;
        int off;
        acc_valid = a;
        acc_hit   = h;
        acc_way   = WAY_W'(w);
        acc_set   = SET_W'(s);
        exp_valid = 1'b0;
        exp_way   = 0;
        exp_mru   = 1'b0;
        if (m_ready && a) begin
            exp_valid = 1'b1;
            if (h) begin
                exp_way = w;
                exp_mru = 1'b1;
            end else begin
                exp_way = -1;
                for (int k = 0; k < WAYS; k++) if (exp_way < 0 && !m_vld[s][k]) exp_way = k;
                if (exp_way < 0) begin
                    for (int k = 0; k < WAYS; k++) if (m_rank[s][k] == WAYS - 1) exp_way = k;
                end
                bim = (m_rnd[BIM_BITS-1:0] == 0);
                off = s % STRIDE;
                if (off == 0) begin
                    exp_mru = 1'b1;
                    if (m_psel < PSEL_MAXV) m_psel++;
                end else if (off == STRIDE - 1) begin
                    exp_mru = bim;
                    if (m_psel > 0) m_psel--;
                end else begin
                    exp_mru = (m_psel >= (1 << (PSEL_W - 1))) ? bim : 1'b1;
                end
                m_vld[s][exp_way] = 1'b1;
            end
            move_to(s, exp_way, exp_mru ? 0 : WAYS - 1);
        end
        if (!m_ready) begin
            m_sweep++;
            if (m_sweep == SETS) m_ready = 1'b1;
        end
        m_rnd = ref_next(m_rnd);
        @(posedge clk);
        @(negedge clk);
        check(ready == m_ready, tag, "ready", int'(ready), int'(m_ready));
        check(rsp_valid == exp_valid, tag, "rsp_valid", int'(rsp_valid), int'(exp_valid));
        if (exp_valid && rsp_valid) begin
            check(int'(rsp_way) == exp_way, tag, "rsp_way", int'(rsp_way), exp_way);
            check(rsp_mru == exp_mru, tag, "rsp_mru", int'(rsp_mru), int'(exp_mru));
            for (int k = 0; k < WAYS; k++) begin
                check(int'(rsp_stack[k*WAY_W +: WAY_W]) == m_rank[s][k], tag, "rank",
                      int'(rsp_stack[k*WAY_W +: WAY_W]), m_rank[s][k]);
            end
        end
    endtask

    // pick a valid way of set s as a hit candidate, -1 if none
    function automatic int valid_way(input int s, input int pick);
        int cnt = 0;
        for (int k = 0; k < WAYS; k++) if (m_vld[s][k]) cnt++;
        if (cnt == 0) return -1;
        pick = pick % cnt;
        for (int k = 0; k < WAYS; k++) begin
            if (m_vld[s][k]) begin
                if (pick == 0) return k;
                pick--;
            end
        end
        return -1;
    endfunction

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;

        // R1: sweep, with accesses presented that must be ignored
        for (int i = 0; i < SETS; i++) tick(1'b1, 1'b0, 0, 9, "R1");

        // R10: idle cycle
        tick(1'b0, 1'b0, 0, 9, "R10");

        // R3 / R4: fill a recency leader, then overflow it
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, 0, 0, "R4");
        // R2: hits promote
        tick(1'b1, 1'b1, 2, 0, "R2");
        tick(1'b1, 1'b1, 0, 0, "R2");
        tick(1'b1, 1'b1, 0, 0, "R2");

        // R5 / R6: bimodal leader fills
        for (int i = 0; i < 80; i++) tick(1'b1, 1'b0, 0, 7, "R5");
        tick(1'b1, 1'b1, 1, 7, "R2");

        // R8: follower while selector low
        for (int i = 0; i < 10; i++) tick(1'b1, 1'b0, 0, 3, "R8");

        // R7: drive selector to the top (misses across recency leaders)
        for (int i = 0; i < 700; i++) tick(1'b1, 1'b0, 0, (i % LEADERS) * STRIDE, "R7");
        // R8: follower now bimodal
        for (int i = 0; i < 80; i++) tick(1'b1, 1'b0, 0, 3 + (i % 4), "R8");

        // R7: drive selector to the bottom
        for (int i = 0; i < 1200; i++) tick(1'b1, 1'b0, 0, (i % LEADERS) * STRIDE + STRIDE - 1, "R7");
        for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, 0, 12, "R8");

        // R9 / R10: random mix
        for (int i = 0; i < 3000; i++) begin
            int s = int'($urandom_range(0, SETS - 1));
            int hw = valid_way(s, int'($urandom_range(0, 7)));
            int kind = int'($urandom_range(0, 9));
            if (kind == 0) tick(1'b0, 1'b1, 1, s, "R10");
            else if (kind < 5 && hw >= 0) tick(1'b1, 1'b1, hw, s, "R9");
            else tick(1'b1, 1'b0, 0, s, "R9");
        end

        acc_valid = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule